// File: doc/BRIEF.md
# Split-Bank ISA Interrupt Mask and Vector Unit

This unit is the host-side collector for a row of ISA interrupt request lines. The lines are grouped into equal banks, and each bank has a two-entry register window. The first entry is an end-of-interrupt command that wipes that bank's pending bits. The second entry is an active-low mask byte: a written 1 blocks the line.

The pending bits are ANDed with the enable mask. The result drives a single CPU request output. It also feeds a lowest-index encoder, whose result software reads back as the interrupt vector.

The register address is `{bank, offset}` for the bank windows. The address directly after the last bank window is the vector register. With the defaults (two banks of eight lines) the map is:

- 0: low-bank clear
- 1: low-bank mask
- 2: high-bank clear
- 3: high-bank mask
- 4: vector
- 5 to 7: undefined

Top module: `isa_irq_mask_vec`

## Requirements
- R1: After reset the enable mask reads 0xFFFF (all lines enabled), no line is pending, `cpu_irq` is 0 and `rd_data` is 0.
- R2: Each pending bit takes the level of its request line at every clock edge: it is set one cycle after the line is high and cleared one cycle after the line is low.
- R3: A write to a bank's mask address (odd address, bank = address >> 1) stores the bitwise inverse of `wr_data` into that bank's byte of the enable mask. The other bank's byte keeps its value.
- R4: A read of either bank's mask address returns the full 16-bit enable mask on `rd_data` one cycle after `rd_en`.
- R5: Any write to a bank's clear address (even address) clears all pending bits of that bank in that cycle, whatever the data. The clear wins over a high request line in the same cycle. The other bank's pending bits are untouched.
- R6: `cpu_irq` is 1 exactly when some line is both pending and enabled.
- R7: A read of the vector address (4) returns the index 0..15 of the lowest line that is pending and enabled, or 0 when there is none.
- R8: Reads of clear addresses and of undefined addresses (5, 6, 7) return 0. Writes to the vector address or to undefined addresses leave the enable mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| irq_in | input | 16 | Request lines, bit i is line i |
| reg_addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe; `rd_data` loads on this edge |
| rd_data | output | 16 | Registered read data, holds between reads |
| cpu_irq | output | 1 | Combined request to the CPU |

## Verification
The bench builds the block with its defaults: two banks of eight lines. This gives a 16-bit mask that crosses the bank boundary, so writes to one byte can be checked for leaving the other alone. It also leaves three undefined addresses above the vector register to probe. With this width the encoder can be pushed to both ends (line 0 and line 15). The priority can also be checked across the bank seam, where line 8 must beat line 15 and line 1 must beat line 8. The one-cycle race between a bank clear and a still-high line is visible at the vector read and at `cpu_irq`.

// File: rtl/isa_irq_pkg.sv
`timescale 1ns/1ps
package isa_irq_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_EOI  = 2'd1,
    ACC_MASK = 2'd2,
    ACC_VEC  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/irq_reg_decode.sv
`timescale 1ns/1ps
module irq_reg_decode
  import isa_irq_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int ADDR_W     = 3,
  parameter int BANK_IDX_W = 1
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output acc_kind_e             kind_o,
  output logic [BANK_IDX_W-1:0] bank_o
);
  localparam int WIN_COUNT = 2 * NUM_BANKS;
  localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(WIN_COUNT);

  always_comb begin
    kind_o = ACC_NONE;
    bank_o = BANK_IDX_W'(addr_i >> 1);
    if (int'(addr_i) < WIN_COUNT) begin
      kind_o = addr_i[0] ? ACC_MASK : ACC_EOI;
    end else if (addr_i == VEC_ADDR) begin
      kind_o = ACC_VEC;
    end
  end
endmodule

// File: rtl/irq_bank.sv
`timescale 1ns/1ps
module irq_bank #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] irq_i,
  input  logic              eoi_wr_i,
  input  logic              mask_wr_i,
  input  logic [BANK_W-1:0] wr_data_i,
  output logic [BANK_W-1:0] pend_o,
  output logic [BANK_W-1:0] en_o
);
  logic [BANK_W-1:0] pend_d, pend_q;
  logic [BANK_W-1:0] en_d, en_q;
  logic              en_load;

  // A bank clear overrides the request level for one cycle.
  always_comb begin
    pend_d = eoi_wr_i ? '0 : irq_i;
  end

  // The mask byte is stored inverted: a written 1 blocks the line.
  always_comb begin
    en_load = mask_wr_i;
    en_d    = ~wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '1;
    end else if (en_load) begin
      en_q <= en_d;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_lowest_vec.sv
`timescale 1ns/1ps
module irq_lowest_vec #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o
);
  // Scan from the top so the lowest set bit is written last.
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/isa_irq_mask_vec.sv
`timescale 1ns/1ps
module isa_irq_mask_vec
  import isa_irq_pkg::*;
#(
  parameter  int BANK_W     = 8,
  parameter  int NUM_BANKS  = 2,
  localparam int NUM_LINES  = BANK_W * NUM_BANKS,
  localparam int ADDR_W     = $clog2(2 * NUM_BANKS + 1),
  localparam int IDX_W      = $clog2(NUM_LINES),
  localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 wr_en,
  input  logic [BANK_W-1:0]    wr_data,
  input  logic                 rd_en,
  output logic [NUM_LINES-1:0] rd_data,
  output logic                 cpu_irq
);
  acc_kind_e              acc_kind;
  logic [BANK_IDX_W-1:0]  acc_bank;
  logic [NUM_LINES-1:0]   pend_all;
  logic [NUM_LINES-1:0]   en_all;
  logic [NUM_LINES-1:0]   live;
  logic [IDX_W-1:0]       vec_idx;
  logic [NUM_LINES-1:0]   rd_d, rd_q;
  logic                   rd_load;

  irq_reg_decode #(
    .NUM_BANKS  (NUM_BANKS),
    .ADDR_W     (ADDR_W),
    .BANK_IDX_W (BANK_IDX_W)
  ) u_decode (
    .addr_i (reg_addr),
    .kind_o (acc_kind),
    .bank_o (acc_bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (acc_bank == BANK_IDX_W'(b));

    irq_bank #(
      .BANK_W (BANK_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_i     (irq_in[b*BANK_W +: BANK_W]),
      .eoi_wr_i  (wr_en && hit && (acc_kind == ACC_EOI)),
      .mask_wr_i (wr_en && hit && (acc_kind == ACC_MASK)),
      .wr_data_i (wr_data),
      .pend_o    (pend_all[b*BANK_W +: BANK_W]),
      .en_o      (en_all[b*BANK_W +: BANK_W])
    );
  end

  assign live    = pend_all & en_all;
  assign cpu_irq = |live;

  irq_lowest_vec #(
    .N     (NUM_LINES),
    .IDX_W (IDX_W)
  ) u_vec (
    .req_i (live),
    .idx_o (vec_idx)
  );

  // Read path: next value and load enable, then the register.
  always_comb begin
    rd_load = rd_en;
    unique case (acc_kind)
      ACC_MASK: rd_d = en_all;
      ACC_VEC:  rd_d = NUM_LINES'(vec_idx);
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_load) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/isa_irq_mask_vec_chk.sv
`timescale 1ns/1ps
module isa_irq_mask_vec_chk #(
  parameter  int BANK_W    = 8,
  parameter  int NUM_BANKS = 2,
  localparam int NUM_LINES = BANK_W * NUM_BANKS,
  localparam int ADDR_W    = $clog2(2 * NUM_BANKS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_in,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic                 wr_en,
  input logic [BANK_W-1:0]    wr_data,
  input logic                 rd_en,
  input logic [NUM_LINES-1:0] rd_data,
  input logic                 cpu_irq,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] en
);
  localparam int WIN_COUNT = 2 * NUM_BANKS;

  logic any_mask_wr;
  logic undef_rd;
  logic [NUM_LINES-1:0] pend_q1;
  assign any_mask_wr = wr_en && (int'(reg_addr) < WIN_COUNT) && reg_addr[0];
  assign undef_rd    = rd_en && (int'(reg_addr) > WIN_COUNT);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    localparam logic [ADDR_W-1:0] EOI_A  = ADDR_W'(2 * b);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(2 * b + 1);
    localparam logic [NUM_LINES-1:0] SLICE = NUM_LINES'({BANK_W{1'b1}}) << (b * BANK_W);

    // R3: the targeted byte takes the inverted data
    assert_mask_inverted_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == MASK_A) |=> (en[b*BANK_W +: BANK_W] == ~$past(wr_data)));

    // R3: the rest of the mask does not move
    assert_mask_other_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == MASK_A) |=> (((en ^ $past(en)) & ~SLICE) == '0));

    // R5: a bank clear empties that bank's pending byte
    assert_eoi_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_addr == EOI_A) |=> (pend[b*BANK_W +: BANK_W] == '0));

    for (genvar i = 0; i < BANK_W; i++) begin : g_line_chk
      // R2: a high line with no clear is pending next cycle
      assert_pending_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in[b*BANK_W+i] && !(wr_en && reg_addr == EOI_A)) |=> pend[b*BANK_W+i]);
    end
  end

  // R6: with every line masked there is no CPU request
  assert_all_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !cpu_irq);

  // R2: a low line is never pending on the next cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q1 <= '0;
    else        pend_q1 <= irq_in;
  end
  assert_pending_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~pend_q1) == '0));

  // R8: undefined reads return zero
  assert_undef_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    undef_rd |=> (rd_data == '0));

  // R8: the mask only changes on a mask write
  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_mask_wr |=> $stable(en));
endmodule

bind isa_irq_mask_vec isa_irq_mask_vec_chk #(
  .BANK_W    (BANK_W),
  .NUM_BANKS (NUM_BANKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_in   (irq_in),
  .reg_addr (reg_addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .cpu_irq  (cpu_irq),
  .pend     (pend_all),
  .en       (en_all)
);

// File: tb/test_isa_irq_mask_vec.sv
`timescale 1ns/1ps
module test_isa_irq_mask_vec;
  logic        clk;
  logic        rst_n;
  logic [15:0] irq_in;
  logic [2:0]  reg_addr;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        rd_en;
  logic [15:0] rd_data;
  logic        cpu_irq;

  int n_chk;
  int n_err;
  bit done;

  isa_irq_mask_vec i_isa_irq_mask_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .reg_addr (reg_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .cpu_irq  (cpu_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic drive(input logic [15:0] v);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 cpu_irq", {15'd0, cpu_irq}, 16'h0000);
    check("R1 rd_data", rd_data, 16'h0000);
    rd(3'd1, v); check("R1 mask via low bank", v, 16'hFFFF);
    rd(3'd4, v); check("R1 vector idle", v, 16'h0000);
  endtask

  task automatic t_pending;
    logic [15:0] v;
    drive(16'h0020);
    check("R2 R6 pending raises cpu_irq", {15'd0, cpu_irq}, 16'h0001);
    rd(3'd4, v); check("R7 vector line 5", v, 16'd5);
    drive(16'h0000);
    check("R2 low line drops request", {15'd0, cpu_irq}, 16'h0000);
  endtask

  task automatic t_mask;
    logic [15:0] v;
    wr(3'd1, 8'h0F);
    rd(3'd1, v); check("R3 low byte inverted", v, 16'hFFF0);
    wr(3'd3, 8'hA5);
    rd(3'd3, v); check("R3 R4 high byte inverted, low kept", v, 16'h5AF0);
    rd(3'd1, v); check("R4 same mask from low window", v, 16'h5AF0);
    drive(16'h0003);
    check("R6 masked lines quiet", {15'd0, cpu_irq}, 16'h0000);
    drive(16'h0013);
    check("R6 enabled line requests", {15'd0, cpu_irq}, 16'h0001);
    rd(3'd4, v); check("R7 vector skips masked", v, 16'd4);
    drive(16'h0000);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h00);
    rd(3'd1, v); check("R3 mask restored", v, 16'hFFFF);
  endtask

  task automatic t_vector;
    logic [15:0] v;
    drive(16'h8000);
    rd(3'd4, v); check("R7 top line", v, 16'd15);
    drive(16'h8100);
    rd(3'd4, v); check("R7 line 8 beats 15", v, 16'd8);
    wr(3'd3, 8'h01);
    rd(3'd4, v); check("R7 masked line 8 skipped", v, 16'd15);
    wr(3'd3, 8'h00);
    drive(16'h0001);
    rd(3'd4, v); check("R7 line 0", v, 16'd0);
    check("R6 line 0 requests", {15'd0, cpu_irq}, 16'h0001);
    drive(16'h0000);
    rd(3'd4, v); check("R7 none pending gives 0", v, 16'd0);
  endtask

  task automatic t_eoi;
    logic [15:0] v;
    drive(16'h0102);
    wr(3'd0, 8'h00);
    check("R5 other bank keeps request", {15'd0, cpu_irq}, 16'h0001);
    rd(3'd4, v); check("R5 low bank cleared, high intact", v, 16'd8);
    rd(3'd4, v); check("R5 R2 line re-pends after clear", v, 16'd1);
    drive(16'h0100);
    wr(3'd2, 8'h5C);
    check("R5 clear beats high line", {15'd0, cpu_irq}, 16'h0000);
    @(negedge clk);
    check("R5 R2 high line returns", {15'd0, cpu_irq}, 16'h0001);
    drive(16'h0104);
    wr(3'd2, 8'hFF);
    rd(3'd4, v); check("R5 high clear spares low bank", v, 16'd2);
    drive(16'h0000);
  endtask

  task automatic t_undef;
    logic [15:0] v;
    wr(3'd4, 8'hFF);
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    wr(3'd0, 8'hFF);
    rd(3'd1, v); check("R8 mask untouched by other writes", v, 16'hFFFF);
    rd(3'd6, v); check("R8 undefined read 6", v, 16'h0000);
    rd(3'd1, v);
    rd(3'd5, v); check("R8 undefined read 5", v, 16'h0000);
    rd(3'd3, v);
    rd(3'd7, v); check("R8 undefined read 7", v, 16'h0000);
    rd(3'd1, v);
    rd(3'd2, v); check("R8 clear address reads 0", v, 16'h0000);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; irq_in = '0; reg_addr = '0;
    wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pending();
    t_mask();
    t_vector();
    t_eoi();
    t_undef();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule